// File: doc/BRIEF.md
# Status-Coded Bus Master Transmitter

This block drives an open-drain two-wire serial bus as a transmitting master. It is steered by a handful of control bits that software writes together in one strobe: enable, start request, stop request and the interrupt flag. Once the start request is set, the engine waits for an idle bus. It then opens a transfer, sends an address byte and sends data bytes, all MSB first. After each completed bus event it raises the interrupt flag and posts an eight-bit status code. It then parks with SCL held low until software clears the flag.

The action that follows a cleared flag depends only on the start and stop request bits written with the clear. Both low sends the byte held in the data register. A start request alone produces a repeated START. A stop request alone closes the transfer. Both together close the transfer and then open a new one. The engine clears the stop request bit by itself once the STOP has been put on the bus. If another master wins the bus (a released SDA is sampled low), the engine posts a fixed status and lets go of both lines.

Top module: `i2c_mtx_engine`

## Requirements
- R1: After reset the interrupt flag is 0, the status reads 0xF8, and neither SCL nor SDA is pulled low.
- R2: A transfer starts only while both enable and start request are set. The engine drives neither line while the bus is busy, meaning a START has been seen on the lines and no STOP since. Once the bus is free it makes SDA fall while SCL is high, sets the flag and reports 0x08.
- R3: While the flag is clear and both request bits are 0, the loaded byte is sent MSB first, with SDA changing only while SCL is low. For the first byte after a START or repeated START, a ninth-clock ACK (SDA low) gives 0x18 and a not-ACK (SDA high) gives 0x20.
- R4: A later byte gives 0x28 on ACK and 0x30 on not-ACK.
- R5: While the flag is set after a normal event, SCL stays pulled low and no further bus activity takes place.
- R6: Clearing the flag with start=1 and stop=0 sends a repeated START, then sets the flag with status 0x10.
- R7: Clearing the flag with stop=1 and start=0 sends a STOP (SDA rising while SCL is high). The stop bit then reads 0, the flag stays 0, the status reads 0xF8 and both lines are released.
- R8: Clearing the flag with start=1 and stop=1 sends a STOP and then a fresh START, after which the status reads 0x08 and the stop bit reads 0.
- R9: If SDA reads low while SCL is high during a data bit in which the engine releases SDA, the engine sets the flag, reports 0x38 and releases both lines.
- R10: A control write with the flag bit at 1 leaves the flag unchanged. When a clearing write falls in the same cycle as the hardware setting the flag, the flag ends up set. The status reads 0xF8 whenever the flag is 0.
- R11: Writing enable=0 abandons any activity within a few cycles: the flag drops to 0, the status reads 0xF8, and both lines stay released.
- R12: During a byte, every SCL high phase and every SCL low phase lasts 2*DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Strobe that writes all control bits at once |
| ctl_en | input | 1 | Enable value to write |
| ctl_sta | input | 1 | Start request value to write |
| ctl_sto | input | 1 | Stop request value to write |
| ctl_flag | input | 1 | Flag value to write (0 clears, 1 leaves unchanged) |
| dat_wr | input | 1 | Strobe that loads the data register |
| dat_in | input | 8 | Byte to load |
| irq_flag | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| sto_bit | output | 1 | Current stop request bit |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
Two things can land on the same clock edge: a software write that clears the flag, and the engine setting the flag at the end of the acknowledge bit. The bench provokes the clash by issuing clearing writes on every cycle of a byte, with both request bits at 0, and stops the writes as soon as it sees the flag high. One of those writes therefore coincides with the set. The result is judged correct if the flag stays high, the status shows the address-acknowledge code, and the bus stays parked. A second coincidence, a software write and the self-clearing of the stop bit, is resolved in favour of the write by construction.

// File: rtl/i2c_mtx_engine.sv
module i2c_mtx_engine #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       ctl_en,
  input  logic       ctl_sta,
  input  logic       ctl_sto,
  input  logic       ctl_flag,
  input  logic       dat_wr,
  input  logic [7:0] dat_in,
  output logic       irq_flag,
  output logic [7:0] status,
  output logic       sto_bit,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [7:0] ST_IDLE = 8'hF8;
  localparam logic [7:0] ST_LOST = 8'h38;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_BYTE, S_HOLD, S_STOP, S_LOST} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh, dreg;
  logic          en_q, sta_q, addr_ph, rep, nack;
  logic          s_scl, s_sda, p_scl, p_sda, busy;

  wire tick    = (cnt == CW'(DIV - 1));
  wire run     = (st == S_START) || (st == S_BYTE) || (st == S_STOP);
  wire freebus = !busy && s_scl && s_sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_scl, s_sda, p_scl, p_sda} <= 4'hF;
      busy <= 1'b0;
    end else begin
      s_scl <= scl_in;
      s_sda <= sda_in;
      p_scl <= s_scl;
      p_sda <= s_sda;
      if (p_scl && s_scl && p_sda && !s_sda)      busy <= 1'b1;
      else if (p_scl && s_scl && !p_sda && s_sda) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  ph <= '0;  bitn <= '0;
      sh <= '0;  dreg <= '0;  en_q <= 1'b0;  sta_q <= 1'b0;  sto_bit <= 1'b0;
      addr_ph <= 1'b0;  rep <= 1'b0;  nack <= 1'b0;
      irq_flag <= 1'b0;  status <= ST_IDLE;  scl_pull <= 1'b0;  sda_pull <= 1'b0;
    end else begin
      if (dat_wr) dreg <= dat_in;
      if (ctl_wr && !ctl_flag) begin
        irq_flag <= 1'b0;
        status   <= ST_IDLE;
      end
      cnt <= (run && !tick) ? cnt + 1'b1 : '0;
      if (!run)      ph <= '0;
      else if (tick) ph <= ph + 2'd1;

      if (!en_q) begin
        st <= S_IDLE;  scl_pull <= 1'b0;  sda_pull <= 1'b0;
        irq_flag <= 1'b0;  status <= ST_IDLE;
      end else begin
        case (st)
          S_IDLE: if (sta_q) st <= S_WAIT;
          S_WAIT: if (freebus) begin
            st  <= S_START;
            rep <= 1'b0;
          end
          S_START: if (tick) begin
            case (ph)
              2'd0: scl_pull <= 1'b0;
              2'd1: sda_pull <= 1'b1;
              2'd3: begin
                scl_pull <= 1'b1;
                st       <= S_HOLD;
                irq_flag <= 1'b1;
                status   <= rep ? 8'h10 : 8'h08;
                addr_ph  <= 1'b1;
              end
              default: ;
            endcase
          end
          S_HOLD: if (!irq_flag) begin
            if (sto_bit) begin
              st       <= S_STOP;
              sda_pull <= 1'b1;
            end else if (sta_q) begin
              st       <= S_START;
              rep      <= 1'b1;
              sda_pull <= 1'b0;
            end else begin
              st   <= S_BYTE;
              sh   <= dreg;
              bitn <= '0;
            end
          end
          S_BYTE: if (tick) begin
            case (ph)
              2'd0: sda_pull <= bitn[3] ? 1'b0 : !sh[7];
              2'd1: scl_pull <= 1'b0;
              2'd2: begin
                if (!bitn[3] && !sda_pull && !s_sda) begin
                  st       <= S_LOST;
                  irq_flag <= 1'b1;
                  status   <= ST_LOST;
                end
                nack <= s_sda;
              end
              default: begin
                scl_pull <= 1'b1;
                if (bitn[3]) begin
                  st       <= S_HOLD;
                  irq_flag <= 1'b1;
                  addr_ph  <= 1'b0;
                  status   <= addr_ph ? (nack ? 8'h20 : 8'h18) : (nack ? 8'h30 : 8'h28);
                end else begin
                  bitn <= bitn + 4'd1;
                  sh   <= {sh[6:0], 1'b0};
                end
              end
            endcase
          end
          S_STOP: if (tick) begin
            if (ph == 2'd1) scl_pull <= 1'b0;
            if (ph == 2'd3) begin
              sda_pull <= 1'b0;
              sto_bit  <= 1'b0;
              st       <= S_IDLE;
            end
          end
          S_LOST: if (!irq_flag) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end

      if (ctl_wr) begin
        en_q    <= ctl_en;
        sta_q   <= ctl_sta;
        sto_bit <= ctl_sto;
      end
    end
  end

  a_r2_quiet_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (!scl_pull && !sda_pull));

  a_r3_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BYTE && $past(st) == S_BYTE && !scl_pull && !$past(scl_pull)) |-> $stable(sda_pull));

  a_r5_hold_keeps_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && status != ST_LOST) |-> scl_pull);

  a_r7_stop_leaves_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sto_bit) && !$past(ctl_wr)) |-> (!scl_pull && !sda_pull && !irq_flag));

  a_r9_lost_releases_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && status == ST_LOST) |-> (!scl_pull && !sda_pull));

  a_r10_clear_flag_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag |-> (status == ST_IDLE));

endmodule

// File: tb/i2c_mtx_engine_bench.sv
module i2c_mtx_engine_bench;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_en = 0, ctl_sta = 0, ctl_sto = 0, ctl_flag = 1;
  logic dat_wr = 0;
  logic [7:0] dat_in = 8'h00;
  logic irq_flag, sto_bit, scl_pull, sda_pull;
  logic [7:0] status;
  logic sda_slv = 1'b0, sda_frc = 1'b0, ack_en = 1'b1;
  wire scl_w = !scl_pull;
  wire sda_w = !(sda_pull | sda_slv | sda_frc);

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = !clk;

  i2c_mtx_engine #(.DIV(DIV)) u_i2c_mtx_engine (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_sta(ctl_sta),
    .ctl_sto(ctl_sto), .ctl_flag(ctl_flag), .dat_wr(dat_wr), .dat_in(dat_in),
    .irq_flag(irq_flag), .status(status), .sto_bit(sto_bit),
    .scl_in(scl_w), .sda_in(sda_w), .scl_pull(scl_pull), .sda_pull(sda_pull));

  // target model on the wires
  logic [7:0] rx_sh = 0, last_byte = 0;
  int bitc = 0, nbytes = 0, nstart = 0, nstop = 0;
  logic active = 0, ackph = 0;
  always @(negedge sda_w) if (scl_w) begin nstart++; active = 1; bitc = 0; ackph = 0; sda_slv = 0; end
  always @(posedge sda_w) if (scl_w) begin nstop++; active = 0; end
  always @(posedge scl_w) if (active && bitc < 8) begin rx_sh = {rx_sh[6:0], sda_w}; bitc++; end
  always @(negedge scl_w) if (active) begin
    if (ackph) begin sda_slv = 0; ackph = 0; bitc = 0; last_byte = rx_sh; nbytes++; end
    else if (bitc == 8) begin sda_slv = ack_en; ackph = 1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic ctl(input bit en, input bit sta, input bit sto, input bit fl);
    @(negedge clk);
    ctl_wr = 1; ctl_en = en; ctl_sta = sta; ctl_sto = sto; ctl_flag = fl;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk);
    dat_wr = 1; dat_in = b;
    @(negedge clk);
    dat_wr = 0;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!irq_flag && n < 4000) begin @(negedge clk); n++; end
    chk(irq_flag, req, irq_flag, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(irq_flag == 0, "R1 flag", irq_flag, 0);
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk(!scl_pull && !sda_pull, "R1 lines", {scl_pull, sda_pull}, 0);
  endtask

  task automatic t_no_enable();
    int s0 = nstart;
    ctl(0, 1, 0, 1);
    idle(300);
    chk(!irq_flag && nstart == s0, "R2 start ignored without enable", nstart - s0, 0);
    ctl(0, 0, 0, 1);
  endtask

  task automatic t_busy_then_start();
    int s0, drv = 0;
    sda_frc = 1;
    idle(20);
    s0 = nstart;
    ctl(1, 1, 0, 1);
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (scl_pull || sda_pull) drv++; end
    chk(drv == 0, "R2 quiet while busy", drv, 0);
    sda_frc = 0;
    wait_flag("R2 flag after start");
    chk(status == 8'h08, "R2 start status", status, 8'h08);
    chk(nstart == s0 + 1, "R2 START seen", nstart - s0, 1);
  endtask

  task automatic t_addr_hold();
    int b0 = nbytes, low = 0;
    ack_en = 1;
    load(8'hA4);
    ctl(1, 0, 0, 0);
    wait_flag("R3 flag after address");
    chk(status == 8'h18, "R3 address ack status", status, 8'h18);
    chk(last_byte == 8'hA4, "R3 address MSB first", last_byte, 8'hA4);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (scl_pull && irq_flag) low++; end
    chk(low == 200 && nbytes == b0 + 1, "R5 hold keeps SCL low", low, 200);
  endtask

  task automatic t_data();
    load(8'h3C);
    ctl(1, 0, 0, 0);
    wait_flag("R4 flag data");
    chk(status == 8'h28, "R4 data ack status", status, 8'h28);
    chk(last_byte == 8'h3C, "R4 data byte", last_byte, 8'h3C);
    ack_en = 0;
    load(8'h81);
    ctl(1, 0, 0, 0);
    wait_flag("R4 flag data nack");
    chk(status == 8'h30, "R4 data nack status", status, 8'h30);
    ack_en = 1;
  endtask

  task automatic t_rstart();
    int s0 = nstart;
    ctl(1, 1, 0, 0);
    wait_flag("R6 flag");
    chk(status == 8'h10, "R6 repeated start status", status, 8'h10);
    chk(nstart == s0 + 1, "R6 START seen", nstart - s0, 1);
    ack_en = 0;
    load(8'h52);
    ctl(1, 0, 0, 0);
    wait_flag("R3 flag nack address");
    chk(status == 8'h20, "R3 address nack status", status, 8'h20);
    ack_en = 1;
  endtask

  task automatic t_stop();
    int p0 = nstop, n = 0, rise = 0;
    ctl(1, 0, 1, 0);
    while (nstop == p0 && n < 1000) begin @(negedge clk); n++; end
    idle(10);
    chk(nstop == p0 + 1, "R7 STOP seen", nstop - p0, 1);
    chk(sto_bit == 0, "R7 stop bit self-clears", sto_bit, 0);
    chk(status == 8'hF8 && !scl_pull && !sda_pull, "R7 idle after stop", status, 8'hF8);
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (irq_flag) rise++; end
    chk(rise == 0, "R7 no flag after stop", rise, 0);
  endtask

  task automatic t_stop_start();
    int s0, p0;
    ctl(1, 1, 0, 1);
    wait_flag("R8 first start");
    load(8'hA0);
    ctl(1, 0, 0, 0);
    wait_flag("R8 address");
    s0 = nstart; p0 = nstop;
    ctl(1, 1, 1, 0);
    wait_flag("R8 flag after restart");
    chk(status == 8'h08, "R8 status after stop+start", status, 8'h08);
    chk(nstop == p0 + 1 && nstart == s0 + 1, "R8 stop then start", {nstop - p0, nstart - s0}, 'h11);
    chk(sto_bit == 0, "R8 stop bit cleared", sto_bit, 0);
  endtask

  task automatic t_coincide();
    int n = 0, held = 0;
    load(8'h11);
    while (n < 4000) begin
      @(negedge clk);
      if (n > 2 && irq_flag) break;
      ctl_wr = 1; ctl_en = 1; ctl_sta = 0; ctl_sto = 0; ctl_flag = 0;
      n++;
    end
    ctl_wr = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (irq_flag) held++; end
    chk(held == 50, "R10 set wins over same-cycle clear", held, 50);
    chk(status == 8'h18 && last_byte == 8'h11, "R10 status after clash", status, 8'h18);
    ctl(1, 0, 0, 1);
    idle(50);
    chk(irq_flag && scl_pull, "R10 write of 1 leaves flag", irq_flag, 1);
  endtask

  task automatic t_timing();
    int hi = 0, lo = 0;
    load(8'hF0);
    ctl(1, 0, 0, 0);
    while (!scl_w) @(negedge clk);
    while (scl_w) @(negedge clk);
    while (!scl_w) begin lo++; @(negedge clk); end
    while (scl_w) begin hi++; @(negedge clk); end
    chk(hi == 2 * DIV, "R12 SCL high length", hi, 2 * DIV);
    chk(lo == 2 * DIV, "R12 SCL low length", lo, 2 * DIV);
    wait_flag("R12 byte done");
    chk(status == 8'h28, "R4 status after timed byte", status, 8'h28);
  endtask

  task automatic t_arb();
    load(8'hFF);
    @(negedge clk);
    ctl_wr = 1; ctl_en = 1; ctl_sta = 0; ctl_sto = 0; ctl_flag = 0;
    sda_frc = 1;
    @(negedge clk);
    ctl_wr = 0;
    wait_flag("R9 flag on loss");
    chk(status == 8'h38, "R9 lost status", status, 8'h38);
    chk(!scl_pull && !sda_pull, "R9 lines released", {scl_pull, sda_pull}, 0);
    sda_frc = 0;
    idle(10);
    ctl(1, 0, 0, 0);
    idle(5);
    chk(!irq_flag && status == 8'hF8, "R10 idle code after clear", status, 8'hF8);
  endtask

  task automatic t_abort();
    int drv = 0;
    ctl(1, 1, 0, 1);
    wait_flag("R11 start before abort");
    load(8'h55);
    ctl(1, 0, 0, 0);
    idle(40);
    ctl(0, 0, 0, 1);
    idle(3);
    chk(!irq_flag && status == 8'hF8, "R11 abort status", status, 8'hF8);
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (scl_pull || sda_pull) drv++; end
    chk(drv == 0, "R11 lines released", drv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_no_enable();
    t_busy_then_start();
    t_addr_hold();
    t_data();
    t_rstart();
    t_stop();
    t_stop_start();
    t_coincide();
    t_timing();
    t_arb();
    t_abort();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end
endmodule